// File: doc/BRIEF.md
# Line-21 Closed Caption Encoder

This block inserts caption or extended-data characters into a digital luma sample stream. Software writes two characters per field into one of two field buffers. On the selected vertical-blanking line of the matching field, the block replaces the incoming video with a two-level waveform. That waveform is a seven-cycle clock run-in, a three-bit start pattern and sixteen data bits.

Line timing comes from a one-cycle line strobe, which is qualified by a field-start flag and a field identity. The bit period is a whole number of samples (`SAMP_PER_BIT`). Set it to one thirty-second of the line length, so that the bit rate is 32 times the line rate. The same logic therefore serves 60 Hz and 50 Hz systems. On every other line the video passes through with one cycle of latency.

Top module: `caption_inserter`

## Requirements
- R1: After reset `luma_o` is 0 and the caption line register holds 21. On any line that is not the caption line, `luma_o` equals the `video_i` value of the previous cycle.
- R2: A `line_strobe_i` pulse with `field_start_i` high starts line 1 of the field named by `field_i`. Any other strobe advances the line number by one. The line whose number equals the caption line register is replaced from the cycle after its strobe up to and including the cycle of the next strobe.
- R3: Index the samples of the caption line from 0. Let s be that index, d be `LEAD_SAMPLES` and P be `SAMP_PER_BIT`. Samples s < d are low. With k = (s−d)/P and phase (s−d) mod P, periods k=0..6 are run-in: high for phase < P/2 and low otherwise. Period 7 is low, period 8 is low and period 9 is high. Period 10+i carries frame bit i. From period 26 onward the output is low.
- R4: Low samples carry the code `LEVEL_LO`, which is the blanking level. High samples carry the code `LEVEL_HI`, which is about 50 IRE.
- R5: A write with `wr_addr_i`=2 sets the caption line register. Values below `MIN_LINE` store `MIN_LINE`, and values above `MAX_LINE` store `MAX_LINE`. A change takes effect from the next strobe.
- R6: A write with `wr_addr_i`=0 loads the field-0 pair. The first character is taken from `wr_data_i[6:0]` and the second from `wr_data_i[14:8]`. Bits 7 and 15 are ignored. Frame bits 0..7 are the first character's bits 0..6, least significant bit first, then its odd-parity bit. Frame bits 8..15 are the second character in the same layout.
- R7: A pair is sent once. A field whose buffer has not been written since its last caption line sends two null characters, each 0x80: seven zero bits followed by a parity bit of 1.
- R8: A write with `wr_addr_i`=1 loads the field-1 pair. The caption line of a field-1 frame sends only that buffer. Address 3 is ignored.
- R9: A strobe that arrives before the burst completes ends the replacement. The new line is handled as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe_i | input | 1 | One-cycle pulse at the start of each line |
| field_start_i | input | 1 | Marks the strobe that starts line 1 of a field |
| field_i | input | 1 | Field identity, sampled with `field_start_i` |
| video_i | input | VID_W | Incoming luma samples |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0: field-0 pair, 1: field-1 pair, 2: caption line |
| wr_data_i | input | 16 | Write data |
| luma_o | output | VID_W | Outgoing luma samples, registered |

## Verification
Every result at `luma_o` is due exactly one clock edge after the cycle that decides it. Pass-through samples equal `video_i` one cycle earlier. Caption sample s appears after the (s+1)-th edge following the edge that samples the caption line's strobe. A write becomes visible only at the next caption line of its field. The bench's model applies each posedge to its own line, field and sample counters. It produces the value due after that edge, and the bench compares `luma_o` with that value at the following falling edge on every cycle. The bench drives the inputs on falling edges only.

// File: rtl/caption_pkg.sv
package caption_pkg;

    localparam int RUNIN_CYCLES = 7;
    localparam int SYNC_BITS    = 3;
    localparam int PAYLOAD_BITS = 16;
    localparam int LAST_PERIOD  = RUNIN_CYCLES + SYNC_BITS + PAYLOAD_BITS - 1;
    localparam int FIRST_DATA   = RUNIN_CYCLES + SYNC_BITS;

    typedef enum logic [1:0] {
        SEG_IDLE,
        SEG_LEAD,
        SEG_SEND,
        SEG_TAIL
    } seg_e;

    // seven data bits followed by an odd-parity bit
    function automatic logic [7:0] char_with_parity(input logic [6:0] c);
        return {~(^c), c};
    endfunction

endpackage

// File: rtl/caption_line_tracker.sv
module caption_line_tracker #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_strobe_i,
    input  logic              field_start_i,
    input  logic              field_i,
    input  logic [LINE_W-1:0] target_line_i,
    output logic              hit_o,
    output logic              hit_field_o
);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              fld;
    } trk_s;

    trk_s trk_d, trk_q;
    logic [LINE_W-1:0] next_line;

    always_comb begin
        trk_d     = trk_q;
        next_line = trk_q.line;
        if (field_start_i) begin
            next_line = LINE_W'(1);
        end else if (trk_q.line != {LINE_W{1'b1}}) begin
            next_line = trk_q.line + LINE_W'(1);
        end
        hit_field_o = field_start_i ? field_i : trk_q.fld;
        hit_o       = line_strobe_i && (next_line == target_line_i);
        if (line_strobe_i) begin
            trk_d.line = next_line;
            trk_d.fld  = hit_field_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assert_field_start_line1_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe_i && field_start_i) |=> (trk_q.line == LINE_W'(1)));

    assert_line_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !line_strobe_i |=> $stable(trk_q.line));

endmodule

// File: rtl/caption_pair_store.sv
module caption_pair_store #(
    parameter int LINE_W       = 10,
    parameter int MIN_LINE     = 10,
    parameter int MAX_LINE     = 25,
    parameter int DEFAULT_LINE = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [15:0]       wr_data_i,
    input  logic              take_i,
    input  logic              take_field_i,
    output logic [15:0]       frame_o,
    output logic [LINE_W-1:0] line_o
);
    import caption_pkg::*;

    localparam logic [LINE_W-1:0] LINE_MIN = LINE_W'(MIN_LINE);
    localparam logic [LINE_W-1:0] LINE_MAX = LINE_W'(MAX_LINE);
    localparam logic [LINE_W-1:0] LINE_RST = LINE_W'(DEFAULT_LINE);

    typedef struct packed {
        logic [1:0]        vld;
        logic [13:0]       pair0;
        logic [13:0]       pair1;
        logic [LINE_W-1:0] line;
    } st_s;

    st_s st_d, st_q;
    logic [13:0] sel_pair;
    logic [6:0]  ch_a, ch_b;
    logic        sel_vld;

    always_comb begin
        sel_pair = take_field_i ? st_q.pair1 : st_q.pair0;
        sel_vld  = st_q.vld[take_field_i];
        ch_a     = sel_vld ? sel_pair[6:0]  : 7'd0;
        ch_b     = sel_vld ? sel_pair[13:7] : 7'd0;
        frame_o  = {char_with_parity(ch_b), char_with_parity(ch_a)};
        line_o   = st_q.line;
    end

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.vld[take_field_i] = 1'b0;
        end
        if (wr_en_i) begin
            unique case (wr_addr_i)
                2'd0: begin
                    st_d.pair0  = {wr_data_i[14:8], wr_data_i[6:0]};
                    st_d.vld[0] = 1'b1;
                end
                2'd1: begin
                    st_d.pair1  = {wr_data_i[14:8], wr_data_i[6:0]};
                    st_d.vld[1] = 1'b1;
                end
                2'd2: begin
                    if (int'(wr_data_i) < MIN_LINE) begin
                        st_d.line = LINE_MIN;
                    end else if (int'(wr_data_i) > MAX_LINE) begin
                        st_d.line = LINE_MAX;
                    end else begin
                        st_d.line = wr_data_i[LINE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.line <= LINE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assert_line_in_range_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.line >= LINE_MIN) && (st_q.line <= LINE_MAX));

    assert_take_clears_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !wr_en_i) |=> !st_q.vld[$past(take_field_i)]);

endmodule

// File: rtl/caption_bit_engine.sv
module caption_bit_engine #(
    parameter int SAMP_PER_BIT = 27,
    parameter int LEAD_SAMPLES = 240
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_strobe_i,
    input  logic        start_i,
    input  logic [15:0] frame_i,
    output logic        act_o,
    output logic        hi_o
);
    import caption_pkg::*;

    localparam int DLY_W = (LEAD_SAMPLES > 1) ? $clog2(LEAD_SAMPLES) : 1;
    localparam int PH_W  = (SAMP_PER_BIT > 1) ? $clog2(SAMP_PER_BIT) : 1;
    localparam logic [DLY_W-1:0] DLY_END  = DLY_W'(LEAD_SAMPLES - 1);
    localparam logic [PH_W-1:0]  PH_END   = PH_W'(SAMP_PER_BIT - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(SAMP_PER_BIT / 2);
    localparam logic [4:0]       PER_LAST = 5'(LAST_PERIOD);
    localparam logic [4:0]       PER_DATA = 5'(FIRST_DATA);
    localparam logic [4:0]       PER_RUN  = 5'(RUNIN_CYCLES);
    localparam logic [4:0]       PER_ONE  = 5'(FIRST_DATA - 1);

    typedef struct packed {
        logic             act;
        seg_e             seg;
        logic [DLY_W-1:0] dly;
        logic [PH_W-1:0]  ph;
        logic [4:0]       per;
        logic [15:0]      sh;
    } eng_s;

    eng_s eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        if (line_strobe_i) begin
            eng_d.dly = '0;
            eng_d.ph  = '0;
            eng_d.per = '0;
            eng_d.sh  = frame_i;
            if (start_i) begin
                eng_d.act = 1'b1;
                eng_d.seg = SEG_LEAD;
            end else begin
                eng_d.act = 1'b0;
                eng_d.seg = SEG_IDLE;
            end
        end else begin
            unique case (eng_q.seg)
                SEG_LEAD: begin
                    if (eng_q.dly == DLY_END) begin
                        eng_d.seg = SEG_SEND;
                    end else begin
                        eng_d.dly = eng_q.dly + DLY_W'(1);
                    end
                end
                SEG_SEND: begin
                    if (eng_q.ph == PH_END) begin
                        eng_d.ph = '0;
                        if (eng_q.per >= PER_DATA) begin
                            eng_d.sh = eng_q.sh >> 1;
                        end
                        if (eng_q.per == PER_LAST) begin
                            eng_d.seg = SEG_TAIL;
                        end else begin
                            eng_d.per = eng_q.per + 5'd1;
                        end
                    end else begin
                        eng_d.ph = eng_q.ph + PH_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        act_o = eng_q.act;
        hi_o  = 1'b0;
        if (eng_q.seg == SEG_SEND) begin
            if (eng_q.per < PER_RUN) begin
                hi_o = (eng_q.ph < PH_HALF);
            end else if (eng_q.per == PER_ONE) begin
                hi_o = 1'b1;
            end else if (eng_q.per >= PER_DATA) begin
                hi_o = eng_q.sh[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q     <= '0;
            eng_q.seg <= SEG_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assert_period_bound_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.seg == SEG_SEND) |-> (eng_q.per <= PER_LAST));

    assert_act_holds_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (!line_strobe_i && eng_q.act) |=> eng_q.act);

    assert_no_start_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe_i && !start_i) |=> !eng_q.act);

endmodule

// File: rtl/caption_inserter.sv
module caption_inserter #(
    parameter int VID_W        = 10,
    parameter int LEVEL_LO     = 240,
    parameter int LEVEL_HI     = 500,
    parameter int SAMP_PER_BIT = 27,
    parameter int LEAD_SAMPLES = 240,
    parameter int LINE_W       = 10,
    parameter int MIN_LINE     = 10,
    parameter int MAX_LINE     = 25,
    parameter int DEFAULT_LINE = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe_i,
    input  logic             field_start_i,
    input  logic             field_i,
    input  logic [VID_W-1:0] video_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [15:0]      wr_data_i,
    output logic [VID_W-1:0] luma_o
);

    localparam logic [VID_W-1:0] CODE_LO = VID_W'(LEVEL_LO);
    localparam logic [VID_W-1:0] CODE_HI = VID_W'(LEVEL_HI);

    logic              hit, hit_field, eng_act, eng_hi;
    logic [15:0]       frame;
    logic [LINE_W-1:0] cap_line;

    caption_line_tracker #(.LINE_W(LINE_W)) u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_strobe_i (line_strobe_i),
        .field_start_i (field_start_i),
        .field_i       (field_i),
        .target_line_i (cap_line),
        .hit_o         (hit),
        .hit_field_o   (hit_field)
    );

    caption_pair_store #(
        .LINE_W       (LINE_W),
        .MIN_LINE     (MIN_LINE),
        .MAX_LINE     (MAX_LINE),
        .DEFAULT_LINE (DEFAULT_LINE)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .take_i       (hit),
        .take_field_i (hit_field),
        .frame_o      (frame),
        .line_o       (cap_line)
    );

    caption_bit_engine #(
        .SAMP_PER_BIT (SAMP_PER_BIT),
        .LEAD_SAMPLES (LEAD_SAMPLES)
    ) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_strobe_i (line_strobe_i),
        .start_i       (hit),
        .frame_i       (frame),
        .act_o         (eng_act),
        .hi_o          (eng_hi)
    );

    logic [VID_W-1:0] luma_d, luma_q;

    always_comb begin
        luma_d = video_i;
        if (eng_act) begin
            luma_d = eng_hi ? CODE_HI : CODE_LO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            luma_q <= '0;
        end else begin
            luma_q <= luma_d;
        end
    end

    assign luma_o = luma_q;

    assert_two_levels_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        eng_act |=> ((luma_o == CODE_LO) || (luma_o == CODE_HI)));

endmodule

// File: tb/caption_inserter_test.sv
`timescale 1ns/1ps
module caption_inserter_test;

    localparam int VW    = 10;
    localparam int LO    = 240;
    localparam int HI    = 500;
    localparam int SPB   = 4;
    localparam int LEAD  = 6;
    localparam int LMIN  = 10;
    localparam int LMAX  = 25;
    localparam int LL    = 140;
    localparam int NL    = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_strobe = 1'b0;
    logic          field_start = 1'b0;
    logic          field = 1'b0;
    logic [VW-1:0] video = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [VW-1:0] luma_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    caption_inserter #(
        .VID_W(VW), .LEVEL_LO(LO), .LEVEL_HI(HI), .SAMP_PER_BIT(SPB),
        .LEAD_SAMPLES(LEAD), .LINE_W(10), .MIN_LINE(LMIN), .MAX_LINE(LMAX),
        .DEFAULT_LINE(21)
    ) uut (
        .clk(clk), .rst_n(rst_n), .line_strobe_i(line_strobe),
        .field_start_i(field_start), .field_i(field), .video_i(video),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .luma_o(luma_o)
    );

    // ---------------- behavioural reference model ----------------
    int          m_line, m_field, m_cap, m_s, m_capline, m_clamp, m_cut, m_null, m_cfield;
    int          m_pend [2];
    logic [13:0] m_pair [2];
    logic [15:0] m_frame;
    int          exp_val;
    string       exp_tag;
    bit          exp_ok = 0;

    function automatic logic [7:0] par_byte(input logic [6:0] c);
        int ones = 0;
        for (int i = 0; i < 7; i++) ones += c[i];
        return {(ones % 2 == 0) ? 1'b1 : 1'b0, c};
    endfunction

    task automatic model_level(output int v, output string t);
        int w, k, p;
        if (m_s < LEAD) begin
            v = LO; t = (m_s == 0) ? ((m_clamp != 0) ? "R5" : "R2") : "R4";
            return;
        end
        w = m_s - LEAD; k = w / SPB; p = w % SPB;
        if (k < 7) begin v = (p < SPB / 2) ? HI : LO; t = "R3"; end
        else if (k < 9) begin v = LO; t = "R3"; end
        else if (k == 9) begin v = HI; t = "R3"; end
        else if (k < 26) begin
            v = m_frame[k - 10] ? HI : LO;
            t = (m_null != 0) ? "R7" : ((m_cfield == 1) ? "R8" : "R6");
        end else begin v = LO; t = "R4"; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_val = 0; exp_tag = "R1";
            m_line = 0; m_field = 0; m_cap = 0; m_s = 0; m_capline = 21;
            m_clamp = 0; m_cut = 0; m_null = 0; m_cfield = 0;
            m_pend[0] = 0; m_pend[1] = 0; m_pair[0] = '0; m_pair[1] = '0;
            m_frame = '0;
        end else begin
            if (m_cap != 0) begin
                model_level(exp_val, exp_tag);
            end else begin
                exp_val = int'(video);
                exp_tag = (m_cut != 0) ? "R9" : "R1";
                m_cut = 0;
            end
            if (line_strobe) begin
                int nl;
                if (m_cap != 0 && m_s < LEAD + 26 * SPB - 1) m_cut = 1;
                nl = field_start ? 1 : m_line + 1;
                if (field_start) m_field = int'(field);
                m_line = nl;
                if (nl == m_capline) begin
                    logic [13:0] pr;
                    m_cap = 1; m_s = 0; m_cfield = m_field;
                    m_null = (m_pend[m_field] == 0) ? 1 : 0;
                    pr = (m_null != 0) ? 14'd0 : m_pair[m_field];
                    m_frame = {par_byte(pr[13:7]), par_byte(pr[6:0])};
                    m_pend[m_field] = 0;
                end else begin
                    m_cap = 0;
                end
            end else if (m_cap != 0) begin
                m_s++;
            end
            if (wr_en) begin
                if (wr_addr < 2) begin
                    m_pair[wr_addr] = {wr_data[14:8], wr_data[6:0]};
                    m_pend[wr_addr] = 1;
                end else if (wr_addr == 2) begin
                    if (int'(wr_data) < LMIN) begin m_capline = LMIN; m_clamp = 1; end
                    else if (int'(wr_data) > LMAX) begin m_capline = LMAX; m_clamp = 1; end
                    else begin m_capline = int'(wr_data); m_clamp = 0; end
                end
            end
        end
        exp_ok = 1;
    end

    always @(negedge clk) begin
        if (exp_ok && !done) begin
            checks++;
            if (int'(luma_o) != exp_val) begin
                errors++;
                $display("FAIL %s: luma_o=%0d expected=%0d at %0t", exp_tag, luma_o, exp_val, $time);
            end
        end
    end

    always @(negedge clk) video <= video + VW'(37);

    // ---------------- stimulus ----------------
    task automatic do_line(input bit fs, input bit fld, input int len);
        @(negedge clk);
        line_strobe = 1'b1; field_start = fs; field = fld;
        @(negedge clk);
        line_strobe = 1'b0; field_start = 1'b0;
        repeat (len - 2) @(negedge clk);
    endtask

    task automatic do_field(input bit fld, input int cut_line, input int cut_len);
        for (int l = 1; l <= NL; l++) begin
            do_line(l == 1, fld, (l == cut_line) ? cut_len : LL);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;                          // R1 reset value checked above
        reg_write(2'd0, 16'hC241);             // R6: bits 7 and 15 dropped
        reg_write(2'd1, 16'h3A59);             // R8
        do_field(1'b0, 0, 0);                  // R2 R3 on default line 21
        do_field(1'b1, 0, 0);
        do_field(1'b0, 0, 0);                  // R7 null pairs
        do_field(1'b1, 0, 0);
        reg_write(2'd2, 16'd15);               // R5 in range
        reg_write(2'd0, 16'h2E2E);
        reg_write(2'd1, 16'h0D55);
        reg_write(2'd3, 16'hFFFF);             // R8: ignored address
        do_field(1'b0, 0, 0);
        do_field(1'b1, 0, 0);
        reg_write(2'd2, 16'd40);               // R5 clamp high
        reg_write(2'd0, 16'h7F00);
        do_field(1'b0, 0, 0);
        reg_write(2'd2, 16'd3);                // R5 clamp low
        reg_write(2'd1, 16'h1234);
        do_field(1'b1, 0, 0);
        reg_write(2'd0, 16'h6B35);
        do_field(1'b0, 10, 50);                // R9 burst cut by early strobe
        do_field(1'b1, 0, 0);
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: luma_o=%0d expected=end of run", luma_o);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule